// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Reprogrammable Address

This block is a two-wire (I2C) slave that gives a bus master byte-wide access to a small on-chip register memory. SCL and SDA are oversampled by the system clock through synchronizers. The block finds START, repeated START and STOP conditions from the sampled levels. It never drives SDA high. It only asserts an open-drain pull-down enable, and the pad outside the block turns that enable into a low level on the wire.

After a START the slave takes in an address byte. It acknowledges only when the upper seven bits equal its own bus address. That address is held in a register that resets to binary 0110100 and can be rewritten over the bus. In a write, the first data byte sets an internal memory pointer and every later byte is stored at the pointer, which then advances. In a read, the slave returns the byte at the pointer and then advances it. A repeated START keeps the pointer, so a master can set the pointer and then read back with no STOP in between. Values wider than a byte are kept with the high byte at the even address and the low byte at the following odd address.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After a START, the slave takes in an address byte MSB first, laid out as {address[6:0], direction}. When address[6:0] equals its own address, it pulls SDA low through the whole ninth clock. After reset the own address is 7'h34.
- R2: When the address does not match, the slave leaves SDA released in the acknowledge slot. Until the next START or STOP it then ignores the bus: it neither acknowledges nor stores any byte.
- R3: With direction 0, the slave acknowledges every data byte. The first data byte sets the pointer. Each later byte, received MSB first, is stored at the pointer and the pointer then advances by one, so a 16-bit value sent high byte first lands with its high byte at the even address.
- R4: With direction 1, the slave sends the byte at the pointer MSB first and then advances the pointer. After a master acknowledge it sends the next byte. The pointer is kept between transactions.
- R5: A repeated START in the middle of a transaction is accepted as a new address phase and keeps the pointer, so a pointer write followed by a read needs no STOP.
- R6: After the master leaves SDA high in the acknowledge slot of a read byte, the slave drives nothing more until the next START.
- R7: A STOP at any bit position returns the slave to idle. A byte cut short by a STOP is not stored.
- R8: Memory location DEPTH-1 (63 by default) holds the own address. A read returns {1'b0, address}. A write is held pending and replaces the own address only when the current transaction ends with a STOP, so a repeated START before that STOP still matches the old address.
- R9: The pointer wraps from DEPTH-1 to 0.
- R10: After reset the pull-down enable is off and every memory byte reads 0. The enable is on only in a slave acknowledge slot or for a 0 bit of a byte being read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, far faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled level of the SCL wire |
| sda_i | input | 1 | Sampled level of the SDA wire |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |

## Verification
The case that is hardest to reach from the ports is the pending own-address update. The new address has to be written, a repeated START issued while the old address is still live, and only then a STOP. The bench builds this exact sequence by hand from bit-level master tasks, then probes the old and the new address in separate transactions. A further hard case is a STOP cut into the middle of a byte. The bench reaches it with a partial-byte task that sends only a few bits and then closes the bus, after which a read shows whether anything was stored.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [6:0] OWN_ADDR_DEFAULT = 7'b0110100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
        return frame[7:1] == own;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    // [STAGES-1] is the synchronized level, [STAGES] the level one cycle earlier
    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_q[STAGES-1];
    assign scl_prev = scl_q[STAGES];
    assign sda_now  = sda_q[STAGES-1];
    assign sda_prev = sda_q[STAGES];

    always_comb begin
        evt.start    = scl_now && scl_prev && sda_prev && !sda_now;
        evt.stop     = scl_now && scl_prev && !sda_prev && sda_now;
        evt.scl_rise = scl_now && !scl_prev;
        evt.scl_fall = !scl_now && scl_prev;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
    parameter int         DEPTH      = 64,
    parameter int         PTR_W      = 6,
    parameter logic [6:0] ADDR_RESET = 7'h34
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [7:0]       rd_data,
    input  logic             we,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    output logic [6:0]       own_addr
);
    localparam int RSV = DEPTH - 1;

    logic [7:0] cells [DEPTH];
    logic [6:0] own_q;
    logic [6:0] pend_q;
    logic       pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we && wr_ptr != PTR_W'(RSV)) begin
            cells[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= ADDR_RESET;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else begin
            if (commit && pend_v) begin
                own_q  <= pend_q;
                pend_v <= 1'b0;
            end
            if (we && wr_ptr == PTR_W'(RSV)) begin
                pend_q <= wr_data[6:0];
                pend_v <= 1'b1;
            end
        end
    end

    assign rd_data  = (rd_ptr == PTR_W'(RSV)) ? {1'b0, own_q} : cells[rd_ptr];
    assign own_addr = own_q;

endmodule

// File: rtl/i2cs_bus_fsm.sv
module i2cs_bus_fsm
    import i2cs_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic [6:0]       own_addr,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             we,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [7:0]       wr_data,
    output logic             commit,
    output logic             sda_oe
);
    bus_state_e       state_q;
    logic [3:0]       cnt_q;
    logic [7:0]       rx_q;
    logic [7:0]       tx_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] wptr_q;
    logic [7:0]       wdat_q;
    logic             rw_q, first_q, nak_q, oe_q, we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            wptr_q  <= '0;
            wdat_q  <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            nak_q   <= 1'b0;
            oe_q    <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (evt.stop) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
                cnt_q   <= '0;
            end else if (evt.start) begin
                state_q <= ST_ADDR;
                oe_q    <= 1'b0;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (evt.scl_rise) begin
                            rx_q  <= {rx_q[6:0], evt.sda};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (evt.scl_fall && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit(rx_q, own_addr)) begin
                                    oe_q    <= 1'b1;
                                    rw_q    <= rx_q[0];
                                    state_q <= ST_ADDR_ACK;
                                end else begin
                                    state_q <= ST_WAIT;
                                end
                            end else begin
                                oe_q    <= 1'b1;
                                state_q <= ST_WR_ACK;
                                if (first_q) begin
                                    ptr_q   <= rx_q[PTR_W-1:0];
                                    first_q <= 1'b0;
                                end else begin
                                    we_q   <= 1'b1;
                                    wptr_q <= ptr_q;
                                    wdat_q <= rx_q;
                                    ptr_q  <= ptr_q + PTR_W'(1);
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                tx_q    <= rd_data;
                                oe_q    <= ~rd_data[7];
                                ptr_q   <= ptr_q + PTR_W'(1);
                                state_q <= ST_RD_BYTE;
                            end else begin
                                oe_q    <= 1'b0;
                                first_q <= 1'b1;
                                state_q <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (evt.scl_rise) begin
                            cnt_q <= cnt_q + 4'd1;
                        end else if (evt.scl_fall) begin
                            if (cnt_q == 4'd8) begin
                                oe_q    <= 1'b0;
                                cnt_q   <= '0;
                                state_q <= ST_RD_ACK;
                            end else begin
                                oe_q <= ~tx_q[6];
                                tx_q <= {tx_q[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            nak_q <= evt.sda;
                        end else if (evt.scl_fall) begin
                            if (nak_q) begin
                                state_q <= ST_WAIT;
                            end else begin
                                tx_q    <= rd_data;
                                oe_q    <= ~rd_data[7];
                                ptr_q   <= ptr_q + PTR_W'(1);
                                state_q <= ST_RD_BYTE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ptr     = ptr_q;
    assign we      = we_q;
    assign wr_ptr  = wptr_q;
    assign wr_data = wdat_q;
    assign commit  = evt.stop;
    assign sda_oe  = oe_q;

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2cs_pkg::*;
#(
    parameter int         DEPTH       = 64,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_RESET  = OWN_ADDR_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int PTR_W = $clog2(DEPTH);

    bus_evt_t         evt;
    logic [6:0]       own_addr;
    logic [7:0]       rd_data;
    logic [PTR_W-1:0] ptr;
    logic             we;
    logic [PTR_W-1:0] wr_ptr;
    logic [7:0]       wr_data;
    logic             commit;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2cs_bus_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .own_addr (own_addr),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .we       (we),
        .wr_ptr   (wr_ptr),
        .wr_data  (wr_data),
        .commit   (commit),
        .sda_oe   (sda_oe)
    );

    i2cs_regbank #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_RESET(ADDR_RESET)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .rd_ptr   (ptr),
        .rd_data  (rd_data),
        .we       (we),
        .wr_ptr   (wr_ptr),
        .wr_data  (wr_data),
        .commit   (commit),
        .own_addr (own_addr)
    );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       start_c,
    input logic       stop_c,
    input logic [6:0] own_addr
);
    // R10: the pull-down is off once reset has been applied
    p_reset_quiet_r10: assert property (@(posedge clk) rst |=> !sda_oe);

    // R7: a STOP always leaves SDA released
    p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> !sda_oe);

    // R5: a (repeated) START always leaves SDA released
    p_start_release_r5: assert property (@(posedge clk) disable iff (rst)
        start_c |=> !sda_oe);

    // R10: the slave only starts driving while SCL is low
    p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R6: the slave only lets go while SCL is low
    p_oe_fall_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_i);

    // R8: the own address changes only right after a STOP
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !stop_c |=> $stable(own_addr));

    // R7: START and STOP are never seen together
    p_cond_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(start_c && stop_c));

endmodule

bind i2c_regfile_slave i2cs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .start_c  (evt.start),
    .stop_c   (evt.stop),
    .own_addr (own_addr)
);

// File: tb/test_i2c_regfile_slave.sv
module test_i2c_regfile_slave;

    localparam int Q     = 32;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regfile_slave #(.DEPTH(DEPTH)) i_i2c_regfile_slave (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    int stray  = 0;
    bit guard  = 1'b0;
    bit done   = 1'b0;

    // behavioural model of the register file
    logic [7:0] mmem [DEPTH];
    logic [6:0] m_own = 7'h34;
    logic [6:0] m_pend = '0;
    bit         m_pv = 1'b0;

    // per-clock comparison: the model says the slave must be silent while guard is set (R10)
    always @(posedge clk) if (guard && sda_oe) stray++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_rd(input int p);
        return (p == DEPTH - 1) ? {1'b0, m_own} : mmem[p];
    endfunction

    task automatic m_wr(input int p, input logic [7:0] d);
        if (p == DEPTH - 1) begin
            m_pend = d[6:0];
            m_pv   = 1'b1;
        end else begin
            mmem[p] = d;
        end
    endtask

    task automatic tick();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b0; tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b1; tick();
        guard = 1'b1;
        if (m_pv) begin
            m_own = m_pend;
            m_pv  = 1'b0;
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; tick();
            if (i == 0) guard = 1'b1;
            scl_m = 1'b1; tick(); tick();
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        guard = 1'b0;
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        acked = !sda_line;
        tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic recv_byte(input bit nak, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick();
            scl_m = 1'b1; tick();
            b[7-i] = sda_line;
            tick();
            scl_m = 1'b0;
        end
        sda_m = nak; tick();
        scl_m = 1'b1;
        if (nak) guard = 1'b1;
        tick(); tick();
        scl_m = 1'b0; tick();
        sda_m = 1'b1;
    endtask

    task automatic wr_seq(input logic [6:0] a, input int p, input logic [7:0] q[$], input string req);
        bit ak;
        bit exp;
        int pp;
        exp = (a == m_own);
        pp  = p;
        i2c_start();
        send_byte({a, 1'b0}, ak);
        chk(ak == exp, {req, " address ack"}, ak, exp);
        send_byte(p[7:0], ak);
        chk(ak == exp, {req, " pointer ack"}, ak, exp);
        foreach (q[i]) begin
            send_byte(q[i], ak);
            chk(ak == exp, {req, " data ack"}, ak, exp);
            if (exp) begin
                m_wr(pp, q[i]);
                pp = (pp + 1) % DEPTH;
            end
        end
        i2c_stop();
    endtask

    task automatic rd_seq(input logic [6:0] a, input int p, input int n, input string req);
        bit ak;
        logic [7:0] b;
        int pp;
        pp = p;
        i2c_start();
        send_byte({a, 1'b0}, ak);
        chk(ak, {req, " address ack"}, ak, 1);
        send_byte(p[7:0], ak);
        chk(ak, {req, " pointer ack"}, ak, 1);
        i2c_start();
        send_byte({a, 1'b1}, ak);
        chk(ak, {req, " R5 read address ack after repeated start"}, ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            chk(b == m_rd(pp), {req, " read data"}, b, m_rd(pp));
            pp = (pp + 1) % DEPTH;
        end
        i2c_stop();
    endtask

    initial begin
        bit ak;
        logic [7:0] b;
        for (int i = 0; i < DEPTH; i++) mmem[i] = '0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0, "R10 reset pull-down off", sda_oe, 0);
        guard = 1'b1;

        // R1 match at default address, R3 pointer + sequential writes (16-bit ABCD at even 4)
        wr_seq(7'h34, 4, '{8'hAB, 8'hCD, 8'h11}, "R1 R3");
        wr_seq(7'h34, 0, '{8'h77}, "R3");

        // R4 R5: pointer write, repeated start, sequential read
        rd_seq(7'h34, 4, 3, "R4");

        // R4: pointer kept across transactions, R10 untouched byte reads 0
        i2c_start();
        send_byte({7'h34, 1'b1}, ak);
        chk(ak, "R4 direct read ack", ak, 1);
        recv_byte(1'b1, b);
        chk(b == mmem[7], "R4 R10 pointer kept, reset value", b, mmem[7]);
        i2c_stop();

        // R2: mismatched address is ignored
        wr_seq(7'h38, 2, '{8'h55}, "R2");
        rd_seq(7'h34, 2, 1, "R2");

        // R6: after master NAK the slave stays silent
        i2c_start();
        send_byte({7'h34, 1'b0}, ak);
        send_byte(8'd5, ak);
        i2c_start();
        send_byte({7'h34, 1'b1}, ak);
        recv_byte(1'b1, b);
        chk(b == mmem[5], "R6 byte before NAK", b, mmem[5]);
        recv_byte(1'b1, b);
        chk(b == 8'hFF, "R6 bus released after NAK", b, 8'hFF);
        i2c_stop();

        // R7: STOP inside the address byte and inside a data byte
        i2c_start();
        send_bits({7'h34, 1'b0}, 4);
        i2c_stop();
        wr_seq(7'h34, 20, '{8'h3C}, "R7 recovery after cut address");
        i2c_start();
        send_byte({7'h34, 1'b0}, ak);
        send_byte(8'd21, ak);
        send_bits(8'hF0, 3);
        i2c_stop();
        rd_seq(7'h34, 20, 2, "R7 cut byte not stored");

        // R8: own-address register at DEPTH-1
        rd_seq(7'h34, DEPTH - 1, 1, "R8 read own address");
        i2c_start();
        send_byte({7'h34, 1'b0}, ak);
        send_byte(8'(DEPTH - 1), ak);
        send_byte(8'h52, ak);
        chk(ak, "R8 address write ack", ak, 1);
        m_wr(DEPTH - 1, 8'h52);
        i2c_start();
        send_byte({7'h34, 1'b0}, ak);
        chk(ak, "R8 old address live before STOP", ak, 1);
        i2c_stop();
        wr_seq(7'h34, 8, '{8'h99}, "R8 old address refused after STOP");

        // R9: read 63 then wrap to 0, using the new address
        rd_seq(7'h52, DEPTH - 1, 2, "R9 R8 wrap with new address");

        chk(stray == 0, "R10 no drive outside ack/read slots", stray, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule